// File: doc/BRIEF.md
# In-Band Loadable Colour Lookup Table

This block maps every pixel of a video stream through three 256-entry, 8-bit tables, one per colour component, for tasks such as gamma correction. In the normal mapping mode each component indexes its own table. In indexed-colour mode a single 8-bit index, carried on the red lane, reads all three tables at once and produces a full RGB triple. A pass-through mode sends pixels to the output unchanged.

The tables can be filled in two ways. A host writes single entries through a simple write port. Alternatively, the stream itself carries the table contents. The block counts lines from the field start. At the first pixel of the line two lines above the programmed first active line, it captures 768 bytes from the red lane. The bytes are interleaved per entry in red, green, blue order. When a captured byte and a host write fall in the same cycle, the captured byte wins, the host write is dropped, and a busy flag tells the host.

Top module: `inband_rgb_lut`

## Requirements
- R1: Every valid input pixel produces exactly one valid output pixel one clock later, and an invalid input cycle gives out_valid low one clock later. In normal mode (cfg_indexed=0, cfg_bypass=0) the outputs are red table[pix_r], green table[pix_g] and blue table[pix_b].
- R2: With cfg_indexed=1 and cfg_bypass=0, pix_r is the index for all three tables, and pix_g and pix_b have no effect.
- R3: With cfg_bypass=1 the output equals the input components delayed by one clock, whatever cfg_indexed is.
- R4: When host_we is high, host_data is written at host_addr into the table chosen by host_sel (0 red, 1 green, 2 blue, 3 none). Pixels see the new entry from the next clock.
- R5: Line numbering restarts at 0 on a valid pixel with pix_sof and pix_sol both high, and each further valid pixel with pix_sol high adds one. Capture starts at the pix_sol pixel of line cfg_first_line-2, provided cfg_inband_en=1 and cfg_first_line is at least 2.
- R6: From that pixel on, the red lane of each valid pixel is captured as one byte. Byte k goes to entry k/3 of table k mod 3 (0 red, 1 green, 2 blue). Capture continues across line starts and stops after byte 767, so byte 768 is not stored.
- R7: In every cycle that stores a captured byte, host_busy is high and any host write in that cycle is discarded. In all other cycles host_busy is low.
- R8: With cfg_inband_en=0 no byte is captured, host_busy stays low, and the table contents stay unchanged.
- R9: During reset, out_valid and host_busy are low and any capture in progress is cancelled. The table contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_bypass | input | 1 | Pass pixels through unchanged |
| cfg_indexed | input | 1 | Indexed-colour mode, red lane indexes all tables |
| cfg_inband_en | input | 1 | Allow table capture from the stream |
| cfg_first_line | input | LINE_W | Number of the first active line |
| pix_valid | input | 1 | Input pixel valid |
| pix_sol | input | 1 | First pixel of a line (with pix_valid) |
| pix_sof | input | 1 | First pixel of a field (with pix_valid and pix_sol) |
| pix_r | input | DATA_W | Red component, index, or captured byte |
| pix_g | input | DATA_W | Green component |
| pix_b | input | DATA_W | Blue component |
| host_we | input | 1 | Host table write strobe |
| host_sel | input | 2 | Target table: 0 red, 1 green, 2 blue, 3 none |
| host_addr | input | DATA_W | Host entry address |
| host_data | input | DATA_W | Host entry data |
| host_busy | output | 1 | A captured byte is being stored this cycle |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | DATA_W | Mapped red |
| out_g | output | DATA_W | Mapped green |
| out_b | output | DATA_W | Mapped blue |

## Verification
A wrong line count or a wrong capture start moves every captured byte. The fault then appears on the first active line as mapped colours drawn from the wrong entries or the wrong table. A lane counter that is out of step swaps components between tables, and this shows on the first mapped pixel after the load. A faulty capture stop or a faulty collision rule shows at once on host_busy, in the cycle of the byte in question. It also shows later as a host write that was lost or kept, seen when a pixel reads back that entry.

// File: rtl/lut_pkg.sv
// Shared types for the colour lookup block.
// Assumes three colour lanes in red, green, blue order.
package lut_pkg;
    localparam int unsigned LANES = 3;

    typedef enum logic [1:0] {
        LANE_R    = 2'd0,
        LANE_G    = 2'd1,
        LANE_B    = 2'd2,
        LANE_NONE = 2'd3
    } lane_e;
endpackage

// File: rtl/lut_bank.sv
// One colour table: a single write port and an asynchronous read port.
// Assumes the caller registers the read data; the contents have no reset.
module lut_bank #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // store one entry per enabled cycle
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/lut_load_ctrl.sv
// Tracks line numbers and runs the in-band capture window.
// Assumes pix_sol and pix_sof only count when pix_valid is high, and that
// pix_sof always comes together with pix_sol.
module lut_load_ctrl
    import lut_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 8,
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic              pix_sol,
    input  logic              pix_sof,
    input  logic              inband_en,
    input  logic [LINE_W-1:0] first_line,
    output logic              ib_we,
    output lane_e             ib_lane,
    output logic [ADDR_W-1:0] ib_addr
);
    logic [LINE_W-1:0] line_q;
    logic [LINE_W-1:0] cur_line;
    logic              start;
    logic              active_q;
    logic [ADDR_W-1:0] ent_q;
    lane_e             lane_q;
    logic              last;

    // line number of the pixel presented this cycle
    always_comb begin
        if (pix_sof) begin
            cur_line = '0;
        end else if (pix_sol) begin
            cur_line = line_q + LINE_W'(1);
        end else begin
            cur_line = line_q;
        end
    end

    // keep the line count across pixels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (pix_valid && (pix_sol || pix_sof)) begin
            line_q <= cur_line;
        end
    end

    // capture opens at the line start two lines above the first active line
    assign start = pix_valid && pix_sol && inband_en &&
                   (first_line >= LINE_W'(2)) &&
                   (cur_line == first_line - LINE_W'(2));

    assign ib_we   = pix_valid && inband_en && (start || active_q);
    assign ib_lane = start ? LANE_R : lane_q;
    assign ib_addr = start ? '0 : ent_q;
    assign last    = (ib_addr == ADDR_W'(DEPTH - 1)) && (ib_lane == LANE_B);

    // step through the interleaved bytes and close after the final one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            ent_q    <= '0;
            lane_q   <= LANE_R;
        end else if (!inband_en) begin
            active_q <= 1'b0;
        end else if (ib_we) begin
            active_q <= !last;
            if (ib_lane == LANE_B) begin
                lane_q <= LANE_R;
                ent_q  <= ib_addr + ADDR_W'(1);
            end else begin
                lane_q <= lane_e'(ib_lane + 2'd1);
                ent_q  <= ib_addr;
            end
        end
    end
endmodule

// File: rtl/inband_rgb_lut.sv
// Colour lookup stage: three tables map the pixel components, with
// indexed-colour and pass-through modes. The tables are written by the host
// or captured from the stream. Output is registered, one clock of latency.
// Assumes DATA_W-bit components; table depth is 2**DATA_W.
module inband_rgb_lut
    import lut_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_bypass,
    input  logic              cfg_indexed,
    input  logic              cfg_inband_en,
    input  logic [LINE_W-1:0] cfg_first_line,
    input  logic              pix_valid,
    input  logic              pix_sol,
    input  logic              pix_sof,
    input  logic [DATA_W-1:0] pix_r,
    input  logic [DATA_W-1:0] pix_g,
    input  logic [DATA_W-1:0] pix_b,
    input  logic              host_we,
    input  logic [1:0]        host_sel,
    input  logic [DATA_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_data,
    output logic              host_busy,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_r,
    output logic [DATA_W-1:0] out_g,
    output logic [DATA_W-1:0] out_b
);
    localparam int DEPTH = 1 << DATA_W;

    logic                          ib_we;
    lane_e                         ib_lane;
    logic [DATA_W-1:0]             ib_addr;
    logic [LANES-1:0][DATA_W-1:0]  comp;
    logic [LANES-1:0][DATA_W-1:0]  rd_data;
    logic [LANES-1:0]              wr_en;
    logic [DATA_W-1:0]             wr_addr;
    logic [DATA_W-1:0]             wr_data;
    logic                          out_valid_q;
    logic [LANES-1:0][DATA_W-1:0]  out_pix_q;

    lut_load_ctrl #(
        .DEPTH  (DEPTH),
        .ADDR_W (DATA_W),
        .LINE_W (LINE_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_valid  (pix_valid),
        .pix_sol    (pix_sol),
        .pix_sof    (pix_sof),
        .inband_en  (cfg_inband_en),
        .first_line (cfg_first_line),
        .ib_we      (ib_we),
        .ib_lane    (ib_lane),
        .ib_addr    (ib_addr)
    );

    assign comp      = {pix_b, pix_g, pix_r};
    assign wr_addr   = ib_we ? ib_addr : host_addr;
    assign wr_data   = ib_we ? pix_r : host_data;
    assign host_busy = ib_we;

    for (genvar i = 0; i < LANES; i++) begin : g_tbl
        logic [DATA_W-1:0] rd_addr;

        // the captured byte wins the write port over the host
        assign wr_en[i] = ib_we ? (ib_lane == lane_e'(i))
                                : (host_we && (host_sel == 2'(i)));
        assign rd_addr  = cfg_indexed ? pix_r : comp[i];

        lut_bank #(
            .DEPTH  (DEPTH),
            .DATA_W (DATA_W),
            .ADDR_W (DATA_W)
        ) u_bank (
            .clk     (clk),
            .wr_en   (wr_en[i]),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .rd_addr (rd_addr),
            .rd_data (rd_data[i])
        );
    end

    // register the mapped or passed-through pixel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
            out_pix_q   <= '0;
        end else begin
            out_valid_q <= pix_valid;
            if (pix_valid) begin
                out_pix_q <= cfg_bypass ? comp : rd_data;
            end
        end
    end

    assign out_valid = out_valid_q;
    assign out_r     = out_pix_q[0];
    assign out_g     = out_pix_q[1];
    assign out_b     = out_pix_q[2];
endmodule

// File: rtl/lut_chk.sv
// Port-level properties of the colour lookup stage, bound to the top.
module lut_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_bypass,
    input logic              cfg_inband_en,
    input logic              pix_valid,
    input logic [DATA_W-1:0] pix_r,
    input logic [DATA_W-1:0] pix_g,
    input logic [DATA_W-1:0] pix_b,
    input logic              host_busy,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_r,
    input logic [DATA_W-1:0] out_g,
    input logic [DATA_W-1:0] out_b
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);

    // R1
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);

    // R3
    bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && cfg_bypass) |=>
        (out_r == $past(pix_r) && out_g == $past(pix_g) && out_b == $past(pix_b)));

    // R7
    busy_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_busy |-> pix_valid);

    // R8
    busy_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_busy |-> cfg_inband_en);
endmodule

bind inband_rgb_lut lut_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_bypass    (cfg_bypass),
    .cfg_inband_en (cfg_inband_en),
    .pix_valid     (pix_valid),
    .pix_r         (pix_r),
    .pix_g         (pix_g),
    .pix_b         (pix_b),
    .host_busy     (host_busy),
    .out_valid     (out_valid),
    .out_r         (out_r),
    .out_g         (out_g),
    .out_b         (out_b)
);

// File: tb/sim_inband_rgb_lut.sv
// Scoreboard bench: the driver pushes expected pixels, a monitor pops them.
module sim_inband_rgb_lut;
    localparam int DATA_W = 8;
    localparam int LINE_W = 11;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              cfg_bypass = 1'b0, cfg_indexed = 1'b0, cfg_inband_en = 1'b0;
    logic [LINE_W-1:0] cfg_first_line = 11'd5;
    logic              pix_valid = 1'b0, pix_sol = 1'b0, pix_sof = 1'b0;
    logic [7:0]        pix_r = '0, pix_g = '0, pix_b = '0;
    logic              host_we = 1'b0;
    logic [1:0]        host_sel = '0;
    logic [7:0]        host_addr = '0, host_data = '0;
    logic              host_busy, out_valid;
    logic [7:0]        out_r, out_g, out_b;

    inband_rgb_lut #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_bypass(cfg_bypass), .cfg_indexed(cfg_indexed),
        .cfg_inband_en(cfg_inband_en), .cfg_first_line(cfg_first_line),
        .pix_valid(pix_valid), .pix_sol(pix_sol), .pix_sof(pix_sof),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .host_we(host_we), .host_sel(host_sel), .host_addr(host_addr),
        .host_data(host_data), .host_busy(host_busy), .out_valid(out_valid),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    logic [24:0] sbq[$];
    string       sbr[$];
    logic [7:0]  mr[256], mg[256], mb[256];
    logic [24:0] mon_e;
    string       mon_req;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] byte1(input int j);
        return 8'((j * 13 + 7) % 256);
    endfunction

    function automatic logic [7:0] byte2(input int j);
        return 8'((j * 5 + 200) % 256);
    endfunction

    // drive one cycle; a valid pixel pushes its expectation from the model
    task automatic cyc(input logic v, input logic s, input logic f,
                       input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                       input logic hwe, input logic [1:0] hs,
                       input logic [7:0] ha, input logic [7:0] hd,
                       input logic chk, input string req);
        logic [23:0] e;
        @(posedge clk);
        #1;
        pix_valid = v; pix_sol = s; pix_sof = f;
        pix_r = r; pix_g = g; pix_b = b;
        host_we = hwe; host_sel = hs; host_addr = ha; host_data = hd;
        if (v) begin
            if (cfg_bypass)       e = {r, g, b};
            else if (cfg_indexed) e = {mr[r], mg[r], mb[r]};
            else                  e = {mr[r], mg[g], mb[b]};
            sbq.push_back({chk, e});
            sbr.push_back(req);
        end
    endtask

    task automatic idle();
        cyc(0, 0, 0, 8'h0, 8'h0, 8'h0, 0, 2'd0, 8'h0, 8'h0, 0, "");
    endtask

    task automatic hwrite(input logic [1:0] s, input logic [7:0] a, input logic [7:0] d);
        cyc(0, 0, 0, 8'h0, 8'h0, 8'h0, 1, s, a, d, 0, "");
        if (s == 2'd0) mr[a] = d;
        else if (s == 2'd1) mg[a] = d;
        else if (s == 2'd2) mb[a] = d;
    endtask

    task automatic pix(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                       input logic chk, input string req);
        cyc(1, 0, 0, r, g, b, 0, 2'd0, 8'h0, 8'h0, chk, req);
    endtask

    // short unchecked lines 0..2 of a field
    task automatic pre_lines();
        for (int ln = 0; ln < 3; ln++) begin
            cyc(1, 1, (ln == 0), 8'h99, 8'h11, 8'h22, 0, 2'd0, 8'h0, 8'h0, 0, "");
            for (int k = 0; k < 3; k++) pix(8'h99, 8'h11, 8'h22, 0, "");
        end
    endtask

    // scoreboard monitor, samples away from the active edge
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sbq.size() == 0) begin
                check("R1", "unexpected out_valid", 32'd1, 32'd0);
            end else begin
                mon_e   = sbq.pop_front();
                mon_req = sbr.pop_front();
                if (mon_e[24]) begin
                    check(mon_req, "out_r", {24'd0, out_r}, {24'd0, mon_e[23:16]});
                    check(mon_req, "out_g", {24'd0, out_g}, {24'd0, mon_e[15:8]});
                    check(mon_req, "out_b", {24'd0, out_b}, {24'd0, mon_e[7:0]});
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL R1 watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 outputs quiet in reset
        check("R9", "out_valid in reset", {31'd0, out_valid}, 32'd0);
        check("R9", "host_busy in reset", {31'd0, host_busy}, 32'd0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R4 host fill of all three tables
        for (int a = 0; a < 256; a++) begin
            hwrite(2'd0, 8'(a), ~8'(a));
            hwrite(2'd1, 8'(a), 8'(a * 3 + 1));
            hwrite(2'd2, 8'(a), 8'(a) ^ 8'h5a);
        end
        hwrite(2'd3, 8'h05, 8'hee); // R4 select 3 writes nothing

        // R1 normal mapping, several patterns including extremes
        pix(8'h00, 8'h00, 8'h00, 1, "R1");
        pix(8'hff, 8'hff, 8'hff, 1, "R1");
        pix(8'h05, 8'h05, 8'h05, 1, "R4");
        pix(8'h12, 8'hc3, 8'h7e, 1, "R1");
        pix(8'h80, 8'h01, 8'hfe, 1, "R1");
        idle();
        hwrite(2'd0, 8'h10, 8'hab);
        pix(8'h10, 8'h10, 8'h10, 1, "R4");
        idle();

        // R2 indexed-colour mode
        cfg_indexed = 1'b1;
        pix(8'h10, 8'h33, 8'h44, 1, "R2");
        pix(8'hfe, 8'h00, 8'hff, 1, "R2");
        pix(8'h00, 8'h77, 8'h88, 1, "R2");
        idle();

        // R3 pass-through overrides indexed mode
        cfg_bypass = 1'b1;
        pix(8'h12, 8'h34, 8'h56, 1, "R3");
        idle();
        cfg_indexed = 1'b0;
        pix(8'hab, 8'hcd, 8'hef, 1, "R3");
        idle();
        cfg_bypass = 1'b0;

        // R5 R6 R7 in-band capture on line 3 for first active line 5
        cfg_inband_en  = 1'b1;
        cfg_first_line = 11'd5;
        pre_lines();
        for (int j = 0; j < 770; j++) begin
            logic hw;
            hw = (j == 100) || (j == 768);
            cyc(1, (j == 0), 0, byte1(j), 8'(j), 8'(j + 1), hw,
                (j == 100) ? 2'd0 : 2'd1, (j == 100) ? 8'h20 : 8'h30,
                (j == 100) ? 8'h11 : 8'h22, 0, "");
            if (j < 768) begin
                case (j % 3)
                    0: mr[j / 3] = byte1(j);
                    1: mg[j / 3] = byte1(j);
                    default: mb[j / 3] = byte1(j);
                endcase
            end
            if (j == 768) mg[8'h30] = 8'h22;
            if (j == 0 || j == 100 || j == 767) begin
                @(negedge clk);
                check("R7", "host_busy during capture", {31'd0, host_busy}, 32'd1);
            end
            if (j == 768) begin
                @(negedge clk);
                check("R6", "host_busy after byte 767", {31'd0, host_busy}, 32'd0);
            end
        end
        cyc(1, 1, 0, 8'h01, 8'h02, 8'h03, 0, 2'd0, 8'h0, 8'h0, 0, "");
        pix(8'h04, 8'h05, 8'h06, 0, "");
        cyc(1, 1, 0, 8'h00, 8'h00, 8'h00, 0, 2'd0, 8'h0, 8'h0, 1, "R6");
        pix(8'h20, 8'h30, 8'hff, 1, "R7");
        pix(8'h55, 8'haa, 8'h7f, 1, "R5");
        pix(8'hff, 8'h00, 8'h01, 1, "R6");
        idle();

        // R8 capture disabled: new field leaves tables unchanged
        cfg_inband_en = 1'b0;
        pre_lines();
        for (int j = 0; j < 40; j++) begin
            cyc(1, (j == 0), 0, byte2(j), 8'h0, 8'h0, 0, 2'd0, 8'h0, 8'h0, 0, "");
            if (j == 0 || j == 10) begin
                @(negedge clk);
                check("R8", "host_busy while disabled", {31'd0, host_busy}, 32'd0);
            end
        end
        cyc(1, 1, 0, 8'h00, 8'h00, 8'h00, 0, 2'd0, 8'h0, 8'h0, 0, "");
        cyc(1, 1, 0, 8'h00, 8'h00, 8'h00, 0, 2'd0, 8'h0, 8'h0, 1, "R8");
        pix(8'h03, 8'h04, 8'h05, 1, "R8");
        idle();
        idle();
        idle();
        check("R1", "scoreboard empty", sbq.size(), 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule